// File: doc/BRIEF.md
# Semi-transparent pixel write-back stage

This stage sits at the end of a pixel pipeline that writes into a 15-bit colour frame buffer. For every pixel it receives the new foreground word, the destination word already read back from memory, and per-primitive controls: a translucency enable, a two-bit blend selector, a flag that forces the top bit of stored words, and a flag that protects destination words whose top bit is set. It decides whether the word is stored at all and, if it is, produces the 16-bit value to store.

Pixels enter on a valid/ready stream. After one register stage the result is presented with a valid bit, a write enable and the data word. The result is held until the downstream write port accepts it. A result with the write enable low still takes one output slot, so the caller can keep its read-back addresses in step.

Top module: `pix_blend_wb`

## Requirements
- R1: After reset, outValid and outWrEn are 0 and inReady is 1.
- R2: A foreground word whose colour bits 14:0 are all zero and whose bit 15 is 0 gives outWrEn=0, whether blendEn is set or not.
- R3: A foreground word that has zero colour with bit 15 set, or nonzero colour with bit 15 clear, is written opaque: outData equals the foreground word when maskSet is 0.
- R4: A foreground word with nonzero colour and bit 15 set is blended only when blendEn is 1. With blendEn 0 it is written opaque.
- R5: Each blended word is computed channel by channel over red (bits 4:0), green (bits 9:5) and blue (bits 14:10), with B the destination channel and F the foreground channel. Blend code 0 gives floor((B+F)/2).
- R6: Blend code 1 gives B+F, saturated at 31.
- R7: Blend code 2 gives B-F, clamped at 0.
- R8: Blend code 3 gives B+floor(F/4), saturated at 31.
- R9: When maskCheck is 1 and destination bit 15 is 1, outWrEn is 0.
- R10: When maskSet is 1, every written word has bit 15 equal to 1. With maskSet 0, bit 15 of a written word is the foreground bit 15.
- R11: A pixel accepted at a clock edge (inValid and inReady both high) appears with outValid=1 right after that edge. outWrEn is never 1 while outValid is 0.
- R12: inReady equals (not outValid) or outReady. While outValid is 1 and outReady is 0, outValid, outWrEn and outData hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Stage can accept an input pixel |
| fgPix | input | PIX_W (16) | Foreground word: bit 15 flag, bits 14:0 colour |
| dstPix | input | PIX_W (16) | Destination word read back from memory |
| blendEn | input | 1 | Translucency enable for the primitive |
| blendMode | input | 2 | Blend equation selector (0..3) |
| maskSet | input | 1 | Force bit 15 of every written word |
| maskCheck | input | 1 | Suppress writes over destination words with bit 15 set |
| outValid | output | 1 | Result slot present |
| outReady | input | 1 | Downstream write port accepts the slot |
| outWrEn | output | 1 | Store outData for this slot |
| outData | output | PIX_W (16) | Word to store |

## Verification
The assertions assume that the input pixel and its controls are meaningful only in cycles where inValid is high, and that the caller pairs each foreground word with the destination word read for the same address. The bench drives every field from a single process on the falling edge, so each accepted pixel carries a consistent set of fields. The assertions also assume that outReady can drop in any cycle. The stimulus backs off outReady and inValid in irregular, overlapping patterns, so stalls land on blended, opaque, transparent and masked slots alike.

// File: rtl/pix_blend_pkg.sv
package pix_blend_pkg;

  typedef enum logic [1:0] {
    BLEND_AVG  = 2'd0,
    BLEND_ADD  = 2'd1,
    BLEND_SUB  = 2'd2,
    BLEND_QADD = 2'd3
  } blend_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new result this edge
    logic doBlend;  // combine with destination
    logic setMask;  // force top bit of stored word
  } blend_strobe_t;

endpackage

// File: rtl/pix_blend_chan.sv
module pix_blend_chan #(
  parameter int CHAN_W = 5
) (
  input  logic [CHAN_W-1:0]          fgChan,
  input  logic [CHAN_W-1:0]          dstChan,
  input  pix_blend_pkg::blend_mode_e mode,
  input  logic                       doBlend,
  output logic [CHAN_W-1:0]          resChan
);
  import pix_blend_pkg::*;

  localparam logic [CHAN_W-1:0] CHAN_MAX = {CHAN_W{1'b1}};

  logic [CHAN_W:0]   sumFull;
  logic [CHAN_W:0]   diffFull;
  logic [CHAN_W:0]   qsumFull;
  logic [CHAN_W-1:0] quarterFg;
  logic [CHAN_W-1:0] avgVal;
  logic [CHAN_W-1:0] addVal;
  logic [CHAN_W-1:0] subVal;
  logic [CHAN_W-1:0] qaddVal;
  logic [CHAN_W-1:0] blended;

  always_comb begin
    quarterFg = fgChan >> 2;
    sumFull   = {1'b0, dstChan} + {1'b0, fgChan};
    diffFull  = {1'b0, dstChan} - {1'b0, fgChan};
    qsumFull  = {1'b0, dstChan} + {1'b0, quarterFg};
    avgVal    = sumFull[CHAN_W:1];
    addVal    = sumFull[CHAN_W]  ? CHAN_MAX : sumFull[CHAN_W-1:0];
    subVal    = diffFull[CHAN_W] ? '0       : diffFull[CHAN_W-1:0];
    qaddVal   = qsumFull[CHAN_W] ? CHAN_MAX : qsumFull[CHAN_W-1:0];
    unique case (mode)
      BLEND_AVG:  blended = avgVal;
      BLEND_ADD:  blended = addVal;
      BLEND_SUB:  blended = subVal;
      BLEND_QADD: blended = qaddVal;
      default:    blended = fgChan;
    endcase
    resChan = doBlend ? blended : fgChan;
  end

endmodule

// File: rtl/pix_blend_dp.sv
module pix_blend_dp #(
  parameter int CHAN_W = 5,
  parameter int N_CHAN = 3,
  localparam int COL_W = CHAN_W * N_CHAN,
  localparam int PIX_W = COL_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pix_blend_pkg::blend_strobe_t  strobe,
  input  pix_blend_pkg::blend_mode_e    mode,
  input  logic [PIX_W-1:0]              fgPix,
  input  logic [COL_W-1:0]              dstColor,
  output logic [PIX_W-1:0]              outData
);
  import pix_blend_pkg::*;

  logic [COL_W-1:0] colorNext;
  logic [PIX_W-1:0] dataQ;

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    pix_blend_chan #(.CHAN_W(CHAN_W)) u_chan (
      .fgChan  (fgPix[ch*CHAN_W +: CHAN_W]),
      .dstChan (dstColor[ch*CHAN_W +: CHAN_W]),
      .mode    (mode),
      .doBlend (strobe.doBlend),
      .resChan (colorNext[ch*CHAN_W +: CHAN_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobe.load) begin
      dataQ <= {fgPix[PIX_W-1] | strobe.setMask, colorNext};
    end
  end

  assign outData = dataQ;

endmodule

// File: rtl/pix_blend_ctrl.sv
module pix_blend_ctrl #(
  parameter int PIX_W = 16,
  localparam int COL_W = PIX_W - 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [PIX_W-1:0]              fgPix,
  input  logic                          dstMask,
  input  logic                          blendEn,
  input  logic                          maskSet,
  input  logic                          maskCheck,
  input  logic                          outReady,
  output logic                          outValid,
  output logic                          outWrEn,
  output pix_blend_pkg::blend_strobe_t  strobe
);
  import pix_blend_pkg::*;

  logic fgFlag;
  logic fgColorZero;
  logic isHole;
  logic isGuarded;
  logic writeNext;
  logic validQ;
  logic wrEnQ;

  always_comb begin
    fgFlag      = fgPix[PIX_W-1];
    fgColorZero = (fgPix[COL_W-1:0] == '0);
    isHole      = fgColorZero && !fgFlag;
    isGuarded   = maskCheck && dstMask;
    writeNext   = !isHole && !isGuarded;
    inReady     = !validQ || outReady;
    strobe.load    = inValid && inReady;
    strobe.doBlend = blendEn && fgFlag && !fgColorZero;
    strobe.setMask = maskSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      wrEnQ  <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
      wrEnQ  <= writeNext;
    end else if (outReady) begin
      validQ <= 1'b0;
      wrEnQ  <= 1'b0;
    end
  end

  assign outValid = validQ;
  assign outWrEn  = wrEnQ;

endmodule

// File: rtl/pix_blend_wb.sv
module pix_blend_wb #(
  parameter int CHAN_W = 5,
  localparam int N_CHAN = 3,
  localparam int PIX_W = CHAN_W * N_CHAN + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] fgPix,
  input  logic [PIX_W-1:0] dstPix,
  input  logic             blendEn,
  input  logic [1:0]       blendMode,
  input  logic             maskSet,
  input  logic             maskCheck,
  output logic             outValid,
  input  logic             outReady,
  output logic             outWrEn,
  output logic [PIX_W-1:0] outData
);
  import pix_blend_pkg::*;

  blend_strobe_t strobe;
  blend_mode_e   mode;

  assign mode = blend_mode_e'(blendMode);

  pix_blend_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inReady   (inReady),
    .fgPix     (fgPix),
    .dstMask   (dstPix[PIX_W-1]),
    .blendEn   (blendEn),
    .maskSet   (maskSet),
    .maskCheck (maskCheck),
    .outReady  (outReady),
    .outValid  (outValid),
    .outWrEn   (outWrEn),
    .strobe    (strobe)
  );

  pix_blend_dp #(.CHAN_W(CHAN_W), .N_CHAN(N_CHAN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mode     (mode),
    .fgPix    (fgPix),
    .dstColor (dstPix[PIX_W-2:0]),
    .outData  (outData)
  );

endmodule

// File: rtl/pix_blend_wb_chk.sv
module pix_blend_wb_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [PIX_W-1:0] fgPix,
  input logic [PIX_W-1:0] dstPix,
  input logic             maskSet,
  input logic             maskCheck,
  input logic             outValid,
  input logic             outReady,
  input logic             outWrEn,
  input logic [PIX_W-1:0] outData
);

  logic accept;
  assign accept = inValid && inReady;

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outWrEn)));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);

  assert_wr_in_slot_R11: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |-> outValid);

  assert_hole_skipped_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && fgPix[PIX_W-2:0] == '0 && !fgPix[PIX_W-1]) |=> !outWrEn);

  assert_guard_skipped_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && maskCheck && dstPix[PIX_W-1]) |=> !outWrEn);

  assert_mask_forced_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accept && maskSet) |=> (!outWrEn || outData[PIX_W-1]));

endmodule

bind pix_blend_wb pix_blend_wb_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .fgPix     (fgPix),
  .dstPix    (dstPix),
  .maskSet   (maskSet),
  .maskCheck (maskCheck),
  .outValid  (outValid),
  .outReady  (outReady),
  .outWrEn   (outWrEn),
  .outData   (outData)
);

// File: tb/pix_blend_wb_tb.sv
`timescale 1ns/1ps
module pix_blend_wb_tb;

  localparam int N_A = 4096;
  localparam int N_B = 256;
  localparam int N_ALL = N_A + N_B;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] fgPix = '0;
  logic [15:0] dstPix = '0;
  logic        blendEn = 1'b0;
  logic [1:0]  blendMode = '0;
  logic        maskSet = 1'b0;
  logic        maskCheck = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        outWrEn;
  logic [15:0] outData;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pix_blend_wb u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .fgPix(fgPix), .dstPix(dstPix), .blendEn(blendEn), .blendMode(blendMode),
    .maskSet(maskSet), .maskCheck(maskCheck), .outValid(outValid),
    .outReady(outReady), .outWrEn(outWrEn), .outData(outData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int chanCalc(input int mode, input int b, input int f);
    int r;
    case (mode)
      0: r = (b + f) / 2;
      1: r = (b + f > 31) ? 31 : b + f;
      2: r = (b - f < 0) ? 0 : b - f;
      default: r = (b + f / 4 > 31) ? 31 : b + f / 4;
    endcase
    return r;
  endfunction

  // expected {wr, data} and tag for the current driven inputs
  task automatic model(output logic [16:0] res, output string tag);
    int fc, dc, flag, res15;
    bit blend, wr;
    logic [15:0] d;
    fc = int'(fgPix[14:0]);
    flag = int'(fgPix[15]);
    blend = (fc != 0) && (flag == 1) && blendEn;
    wr = !((fc == 0) && (flag == 0)) && !(maskCheck && dstPix[15]);
    d = fgPix;
    if (blend) begin
      for (int ch = 0; ch < 3; ch++) begin
        dc = chanCalc(int'(blendMode), int'(dstPix[ch*5 +: 5]), int'(fgPix[ch*5 +: 5]));
        d[ch*5 +: 5] = 5'(dc);
      end
    end
    res15 = (flag == 1 || maskSet) ? 1 : 0;
    d[15] = res15[0];
    res = {wr, d};
    if (fc == 0 && flag == 0) tag = "R2";
    else if (maskCheck && dstPix[15]) tag = "R9";
    else if (maskSet) tag = "R10";
    else if (blend) begin
      case (int'(blendMode))
        0: tag = "R5";
        1: tag = "R6";
        2: tag = "R7";
        default: tag = "R8";
      endcase
    end else if (fc != 0 && flag == 1) tag = "R4";
    else tag = "R3";
  endtask

  task automatic drive_item(input int idx);
    if (idx < N_A) begin
      logic [4:0] f, b;
      f = 5'(idx);
      b = 5'(idx >> 5);
      blendMode = 2'(idx >> 10);
      fgPix  = {1'b1, 5'(31 - int'(f)), b, f};
      dstPix = {f[0], b, f, b};
      blendEn = 1'b1;
      maskSet = 1'b0;
      maskCheck = 1'b0;
    end else begin
      int k, c, v;
      k = idx - N_A;
      c = k % 64;
      v = k / 64;
      blendMode = 2'(v);
      blendEn = c[2];
      maskSet = c[3];
      maskCheck = c[4];
      fgPix[15] = c[1];
      fgPix[14:0] = c[0] ? 15'h0 : {5'(v * 7 + 3), 5'(c + 1), 5'(31 - v)};
      dstPix = {c[5], 5'(c), 5'(v * 9), 5'd17};
    end
  endtask

  initial begin
    logic [16:0] expQ[$];
    string       tagQ[$];
    logic [16:0] res;
    string       tag;
    logic [16:0] exp;
    string       etag;
    logic [15:0] heldData;
    logic        heldWr;
    bit          stallHeld;
    bit          expectValid;
    int          idx;
    int          cyc;
    stallHeld = 0;
    expectValid = 0;
    idx = 0;
    cyc = 0;
    repeat (4) @(negedge clk);
    check("R1", {29'b0, outValid, outWrEn, inReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {29'b0, outValid, outWrEn, inReady}, 32'h1);
    while (idx < N_ALL || expQ.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (expectValid) check("R11", {31'b0, outValid}, 32'h1);
      expectValid = 0;
      if (stallHeld)
        check("R12", {15'b0, outValid, outWrEn, outData}, {15'b0, 1'b1, heldWr, heldData});
      outReady = !((cyc % 7) == 3 || (cyc % 5) == 1);
      if (idx < N_ALL && (cyc % 11) != 6) begin
        drive_item(idx);
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
      #1;
      check("R12", {31'b0, inReady}, {31'b0, !outValid || outReady});
      if (!outValid) check("R11", {31'b0, outWrEn}, 32'h0);
      stallHeld = outValid && !outReady;
      heldData = outData;
      heldWr = outWrEn;
      if (outValid && outReady && expQ.size() > 0) begin
        exp = expQ.pop_front();
        etag = tagQ.pop_front();
        check(etag, {31'b0, outWrEn}, {31'b0, exp[16]});
        if (exp[16]) check(etag, {16'b0, outData}, {16'b0, exp[15:0]});
      end
      if (inValid && inReady) begin
        model(res, tag);
        expQ.push_back(res);
        tagQ.push_back(tag);
        idx++;
        expectValid = 1;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    check("R11", {31'b0, outValid}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule